// File: doc/BRIEF.md
# Dual-Channel PCM Serial Framing Port

This block carries one 8-bit companded sample per channel in every 8 kHz frame over a serial link. Each of the two channels has its own serial receive input and serial transmit output. All traffic is timed by one bit clock and by frame signals. Inside the chip, received samples appear on a parallel bus with a one-cycle strobe. Transmit samples are written into a holding register for each channel.

The port runs in one of two timing modes, chosen at run time through a small configuration strobe.

- **Master (internal) timing.** The port divides the system clock down to make the bit clock and drives it out. It also drives a single active-high frame pulse that starts receive and transmit together.
- **Slave (external) timing.** The bit clock comes in from outside, and receive and transmit each have their own active-low frame input. The falling edge of a frame input starts a sample. Its rising edge commits that sample: on receive, the collected byte is handed over; on transmit, the next byte is staged for the following frame.

All pins that can float are split into a value and an enable, so the pad ring can build the three-state buffers. Reset leaves the port in slave timing, with the bit clock and both transmit outputs floating.

Top module: `pcm_frame_port`

## Requirements
- R1: After reset the port is in slave timing. `sclk_oe_o`, both `dx_oe_o` bits, `frame_o` and `rx_valid_o` are all 0.
- R2: In master timing `sclk_oe_o` is 1 and `sclk_o` repeats every CLKS_PER_BIT system clocks. It rises CLKS_PER_BIT cycles after the switch and is high for the first CLKS_PER_BIT/2 cycles of each period.
- R3: In master timing `frame_o` is high for exactly one bit period out of every FRAME_BITS. It rises together with `sclk_o`, and the first pulse begins at the first bit-clock rise after the switch.
- R4: At a frame start, each channel's sample is driven on `dx_o` MSB first, one bit per bit-clock rise, starting at the start rise itself. In master timing the sample is the holding register's value just before that rise.
- R5: In master timing the receive input is sampled at the 8 bit-clock rises that follow the frame start. The first sampled bit becomes the MSB. `rx_valid_o` is then high for one system clock, together with the byte.
- R6: In slave timing a transmit frame start is the first bit-clock rise at which `txfs_n_i` is seen low. The byte it sends was copied from the holding register at the rise where `txfs_n_i` was last seen going high. This staged byte is 0 after reset and after any mode change.
- R7: In slave timing the received byte is presented at the rise where `rxfs_n_i` is first seen high again. The strobe is given only if all 8 bits arrived since the falling edge; otherwise no strobe is given.
- R8: Channel c uses `dr_i[c]`, `dx_o[c]`, `tx_wr_i[c]`, `tx_data_i[8c+7:8c]` and `rx_data_o[8c+7:8c]`. Channel 0 occupies the low byte.
- R9: `dx_oe_o` is 1 only during the 8 bit periods of a sample shift and 0 at every other time.
- R10: A configuration write that changes the mode abandons any sample in progress. In the next cycle the transmit enables are 0, and `sclk_oe_o` shows the new mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_ext_i | input | 1 | Mode written by cfg_wr_i: 1 slave timing, 0 master timing |
| sclk_i | input | 1 | Bit clock from the pad (slave timing) |
| sclk_o | output | 1 | Generated bit clock (master timing) |
| sclk_oe_o | output | 1 | Bit clock pad drive enable |
| frame_o | output | 1 | Active-high frame pulse (master timing) |
| rxfs_n_i | input | 1 | Active-low receive frame (slave timing) |
| txfs_n_i | input | 1 | Active-low transmit frame (slave timing) |
| dr_i | input | CHANNELS | Serial receive data, one bit per channel |
| dx_o | output | CHANNELS | Serial transmit data, one bit per channel |
| dx_oe_o | output | CHANNELS | Transmit pad drive enables |
| tx_wr_i | input | CHANNELS | Holding register write strobes |
| tx_data_i | input | CHANNELS*SAMPLE_BITS | Holding register write data |
| rx_valid_o | output | 1 | One-cycle received-byte strobe |
| rx_data_o | output | CHANNELS*SAMPLE_BITS | Received bytes |

## Verification
The checks assume that in slave timing the frame and data inputs change only while the bit clock is low. They must also settle at least three system clocks before the bit clock rises, because each input crosses a two-stage synchronizer that shares its delay with the bit clock's edge detector. They further assume the bit clock's half period is longer than that synchronizer delay, and that in master timing the peer drives receive data from the port's own bit clock. The stimulus meets all of these. In slave timing it changes every input at the start of the bit clock's low phase, eight system clocks before the next rising edge. In master timing the receive inputs are looped back from the opposite channel's transmit output, so each bit is driven one full bit period before it is sampled.

// File: rtl/pcm_frame_port.sv
`timescale 1ns/1ps
module pcm_frame_port #(
  parameter int CLKS_PER_BIT = 8,
  parameter int FRAME_BITS   = 256,
  parameter int SAMPLE_BITS  = 8,
  parameter int CHANNELS     = 2
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            cfg_wr_i,
  input  logic                            cfg_ext_i,
  input  logic                            sclk_i,
  output logic                            sclk_o,
  output logic                            sclk_oe_o,
  output logic                            frame_o,
  input  logic                            rxfs_n_i,
  input  logic                            txfs_n_i,
  input  logic [CHANNELS-1:0]             dr_i,
  output logic [CHANNELS-1:0]             dx_o,
  output logic [CHANNELS-1:0]             dx_oe_o,
  input  logic [CHANNELS-1:0]             tx_wr_i,
  input  logic [CHANNELS*SAMPLE_BITS-1:0] tx_data_i,
  output logic                            rx_valid_o,
  output logic [CHANNELS*SAMPLE_BITS-1:0] rx_data_o
);
  localparam int DIVW = $clog2(CLKS_PER_BIT);
  localparam int FCW  = $clog2(FRAME_BITS);
  localparam int CNTW = $clog2(SAMPLE_BITS + 1);
  localparam int HALF = CLKS_PER_BIT / 2;
  localparam logic [DIVW-1:0] DIV_LAST = DIVW'(CLKS_PER_BIT - 1);
  localparam logic [DIVW-1:0] DIV_MID  = DIVW'(HALF - 1);
  localparam logic [FCW-1:0]  FC_LAST  = FCW'(FRAME_BITS - 1);
  localparam logic [CNTW-1:0] CNT_FULL = CNTW'(SAMPLE_BITS);
  localparam logic [CNTW-1:0] CNT_ONE  = CNTW'(1);

  typedef logic [SAMPLE_BITS-1:0] sample_t;

  logic            ext_q, mode_chg;
  logic [DIVW-1:0] div_q;
  logic [FCW-1:0]  fcnt_q;
  logic            sclk_q, fr_q;
  logic            s_meta, s_sync, s_prev;
  logic            rfs_meta, rfs_sync, tfs_meta, tfs_sync;
  logic            rfs_prev, tfs_prev;
  logic [CHANNELS-1:0] dr_meta, dr_sync, dr_s;
  logic            rise_evt, frame_wrap;
  logic            tx_start, tx_commit, rx_start, rx_commit, rx_last;
  logic [CNTW-1:0] tx_cnt, rx_cnt;
  logic            rx_full, rxv_q;
  sample_t hold_q [CHANNELS];
  sample_t next_q [CHANNELS];
  sample_t tsh_q  [CHANNELS];
  sample_t rsh_q  [CHANNELS];
  sample_t rxd_q  [CHANNELS];
  sample_t rx_nxt [CHANNELS];

  assign mode_chg   = cfg_wr_i && (cfg_ext_i != ext_q);
  assign frame_wrap = (fcnt_q == FC_LAST);
  assign rise_evt   = ext_q ? (s_sync && !s_prev) : (div_q == DIV_LAST);
  assign tx_start   = rise_evt && (ext_q ? (tfs_prev && !tfs_sync) : frame_wrap);
  assign tx_commit  = rise_evt && ext_q && !tfs_prev && tfs_sync;
  assign rx_start   = rise_evt && (ext_q ? (rfs_prev && !rfs_sync) : frame_wrap);
  assign rx_commit  = rise_evt && ext_q && !rfs_prev && rfs_sync;
  assign rx_last    = rise_evt && !rx_start && (rx_cnt == CNT_ONE);
  assign dr_s       = ext_q ? dr_sync : dr_i;

  assign sclk_o     = sclk_q;
  assign sclk_oe_o  = !ext_q;
  assign frame_o    = fr_q && !ext_q;
  assign rx_valid_o = rxv_q;

  for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
    assign rx_nxt[c] = {rsh_q[c][SAMPLE_BITS-2:0], dr_s[c]};
    assign dx_o[c]    = tsh_q[c][SAMPLE_BITS-1];
    assign dx_oe_o[c] = (tx_cnt != '0);
    assign rx_data_o[c*SAMPLE_BITS +: SAMPLE_BITS] = rxd_q[c];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_meta <= 1'b0; s_sync <= 1'b0; s_prev <= 1'b0;
      rfs_meta <= 1'b1; rfs_sync <= 1'b1;
      tfs_meta <= 1'b1; tfs_sync <= 1'b1;
      dr_meta <= '0; dr_sync <= '0;
    end else begin
      s_meta <= sclk_i;   s_sync <= s_meta;  s_prev <= s_sync;
      rfs_meta <= rxfs_n_i; rfs_sync <= rfs_meta;
      tfs_meta <= txfs_n_i; tfs_sync <= tfs_meta;
      dr_meta <= dr_i;    dr_sync <= dr_meta;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_q  <= 1'b1;
      div_q  <= '0;
      sclk_q <= 1'b0;
      fcnt_q <= FC_LAST;
      fr_q   <= 1'b0;
    end else if (mode_chg) begin
      ext_q  <= cfg_ext_i;
      div_q  <= '0;
      sclk_q <= 1'b0;
      fcnt_q <= FC_LAST;
      fr_q   <= 1'b0;
    end else if (!ext_q) begin
      if (div_q == DIV_LAST) begin
        div_q  <= '0;
        sclk_q <= 1'b1;
        fcnt_q <= frame_wrap ? '0 : fcnt_q + 1'b1;
        fr_q   <= frame_wrap;
      end else begin
        div_q <= div_q + 1'b1;
        if (div_q == DIV_MID) sclk_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rfs_prev <= 1'b1;
      tfs_prev <= 1'b1;
    end else if (mode_chg) begin
      rfs_prev <= 1'b1;
      tfs_prev <= 1'b1;
    end else if (rise_evt && ext_q) begin
      rfs_prev <= rfs_sync;
      tfs_prev <= tfs_sync;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_cnt <= '0;
      for (int c = 0; c < CHANNELS; c++) begin
        hold_q[c] <= '0; next_q[c] <= '0; tsh_q[c] <= '0;
      end
    end else begin
      for (int c = 0; c < CHANNELS; c++)
        if (tx_wr_i[c]) hold_q[c] <= tx_data_i[c*SAMPLE_BITS +: SAMPLE_BITS];
      if (mode_chg) begin
        tx_cnt <= '0;
        for (int c = 0; c < CHANNELS; c++) next_q[c] <= '0;
      end else begin
        if (tx_commit)
          for (int c = 0; c < CHANNELS; c++) next_q[c] <= hold_q[c];
        if (tx_start) begin
          tx_cnt <= CNT_FULL;
          for (int c = 0; c < CHANNELS; c++) tsh_q[c] <= ext_q ? next_q[c] : hold_q[c];
        end else if (rise_evt && tx_cnt != '0) begin
          tx_cnt <= tx_cnt - 1'b1;
          for (int c = 0; c < CHANNELS; c++) tsh_q[c] <= tsh_q[c] << 1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_cnt  <= '0;
      rx_full <= 1'b0;
      rxv_q   <= 1'b0;
      for (int c = 0; c < CHANNELS; c++) begin
        rsh_q[c] <= '0; rxd_q[c] <= '0;
      end
    end else if (mode_chg) begin
      rx_cnt  <= '0;
      rx_full <= 1'b0;
      rxv_q   <= 1'b0;
    end else begin
      rxv_q <= 1'b0;
      if (rx_start) begin
        rx_cnt  <= CNT_FULL;
        rx_full <= 1'b0;
      end else if (rise_evt && rx_cnt != '0) begin
        rx_cnt <= rx_cnt - 1'b1;
        for (int c = 0; c < CHANNELS; c++) rsh_q[c] <= rx_nxt[c];
        if (rx_last) begin
          if (ext_q) rx_full <= 1'b1;
          else begin
            rxv_q <= 1'b1;
            for (int c = 0; c < CHANNELS; c++) rxd_q[c] <= rx_nxt[c];
          end
        end
      end
      if (rx_commit && (rx_full || rx_last)) begin
        rxv_q   <= 1'b1;
        rx_full <= 1'b0;
        for (int c = 0; c < CHANNELS; c++) rxd_q[c] <= rx_last ? rx_nxt[c] : rsh_q[c];
      end
    end
  end

  AST_FRAME_ON_CLOCK_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_o) |-> sclk_o); // R3
  AST_RX_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o); // R5
  AST_DX_START_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dx_oe_o[0]) |-> $past(rise_evt)); // R4
  AST_DX_RELEASE_ON_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dx_oe_o[0]) |-> $past(rise_evt || mode_chg)); // R9
  AST_SWITCH_TO_SLAVE_FLOATS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_wr_i && cfg_ext_i) |=> (!sclk_oe_o && dx_oe_o == '0)); // R10
endmodule

// File: tb/pcm_frame_port_tb_top.sv
`timescale 1ns/1ps
module pcm_frame_port_tb_top;
  localparam int CPB = 8;
  localparam int FB  = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0, cfg_ext = 1'b1;
  logic sclk_in = 1'b0, rxfs_n = 1'b1, txfs_n = 1'b1;
  logic [1:0] dr_ext = 2'b11, dr_w;
  logic [1:0] tx_wr = 2'b00;
  logic [15:0] tx_data = '0;
  logic sclk_out, sclk_oe, frame, rx_valid;
  logic [1:0] dx, dx_oe;
  logic [15:0] rx_data;
  logic loop_en = 1'b0;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign dr_w = loop_en ? {(dx_oe[0] ? dx[0] : 1'b1), (dx_oe[1] ? dx[1] : 1'b1)} : dr_ext;

  pcm_frame_port #(.CLKS_PER_BIT(CPB), .FRAME_BITS(FB), .SAMPLE_BITS(8), .CHANNELS(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(cfg_wr), .cfg_ext_i(cfg_ext),
    .sclk_i(sclk_in), .sclk_o(sclk_out), .sclk_oe_o(sclk_oe), .frame_o(frame),
    .rxfs_n_i(rxfs_n), .txfs_n_i(txfs_n), .dr_i(dr_w), .dx_o(dx), .dx_oe_o(dx_oe),
    .tx_wr_i(tx_wr), .tx_data_i(tx_data), .rx_valid_o(rx_valid), .rx_data_o(rx_data));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference for master timing
  bit iact = 0;
  int n = 0;
  logic [7:0] hold_m [2];
  logic [7:0] cap_m  [2];

  always @(posedge clk) begin
    if (!rst_n) begin
      iact = 0; hold_m[0] = 0; hold_m[1] = 0; cap_m[0] = 0; cap_m[1] = 0;
    end else begin
      if (cfg_wr && !cfg_ext && !iact) begin iact = 1; n = 0; end
      else if (cfg_wr && cfg_ext) iact = 0;
      else if (iact) begin
        n++;
        if (n % CPB == 0 && ((n / CPB - 1) % FB) == 0) begin
          cap_m[0] = hold_m[0]; cap_m[1] = hold_m[1];
        end
      end
      for (int c = 0; c < 2; c++) if (tx_wr[c]) hold_m[c] = tx_data[c*8 +: 8];
    end
  end

  always @(negedge clk) begin
    if (rst_n && iact && !done) begin
      int m, j;
      bit e_sclk, e_fr, e_oe, e_rv;
      m = n / CPB;
      j = (m >= 1) ? (m - 1) % FB : -1;
      e_sclk = (n >= CPB) && (n % CPB < CPB / 2);
      e_fr = (j == 0);
      e_oe = (j >= 0) && (j < 8);
      e_rv = (j == 8) && (n % CPB == 0);
      chk(sclk_oe == 1'b1, "R2", "sclk_oe", sclk_oe, 1);
      chk(sclk_out == e_sclk, "R2", "sclk_o", sclk_out, e_sclk);
      chk(frame == e_fr, "R3", "frame_o", frame, e_fr);
      chk(dx_oe == {e_oe, e_oe}, "R9", "dx_oe", dx_oe, {e_oe, e_oe});
      if (e_oe)
        chk(dx == {cap_m[1][7-j], cap_m[0][7-j]}, "R4", "dx bits", dx,
            {cap_m[1][7-j], cap_m[0][7-j]});
      chk(rx_valid == e_rv, "R5", "rx_valid", rx_valid, e_rv);
      if (e_rv)
        chk(rx_data == {cap_m[0], cap_m[1]}, "R8", "rx_data crossed loop", rx_data,
            {cap_m[0], cap_m[1]});
    end
  end

  // slave-timing strobe monitor
  int rxv_n = 0;
  logic [15:0] rxv_d = '0;
  always @(negedge clk) if (rst_n && rx_valid) begin rxv_n++; rxv_d = rx_data; end

  logic [1:0] s_oe, s_dx;

  task automatic ext_bit(input logic fst, input logic fsr, input logic [1:0] d);
    @(negedge clk);
    sclk_in = 1'b0; txfs_n = fst; rxfs_n = fsr; dr_ext = d;
    repeat (8) @(negedge clk);
    sclk_in = 1'b1;
    repeat (7) @(negedge clk);
    s_oe = dx_oe; s_dx = dx;
  endtask

  task automatic ext_frame(input int low, input logic [7:0] r0, input logic [7:0] r1,
                           output logic [7:0] g0, output logic [7:0] g1,
                           output int oe_n, output logic [1:0] oe_after);
    oe_n = 0; g0 = 0; g1 = 0; rxv_n = 0;
    for (int i = 1; i <= 10; i++) begin
      logic f;
      logic [1:0] d;
      f = (i <= low) ? 1'b0 : 1'b1;
      d = (i >= 2 && i <= 9) ? {r1[9-i], r0[9-i]} : 2'b11;
      ext_bit(f, f, d);
      if (s_oe[0]) oe_n++;
      if (i <= 8) begin g0[8-i] = s_dx[0]; g1[8-i] = s_dx[1]; end
      if (i == 9) oe_after = s_oe;
    end
  endtask

  task automatic write_hold(input logic [7:0] b0, input logic [7:0] b1);
    @(negedge clk); tx_wr = 2'b11; tx_data = {b1, b0};
    @(negedge clk); tx_wr = 2'b00;
  endtask

  task automatic do_frame(input string tag, input logic [7:0] r0, input logic [7:0] r1,
                          input logic [7:0] e0, input logic [7:0] e1);
    logic [7:0] g0, g1; int oe_n; logic [1:0] oa;
    ext_frame(8, r0, r1, g0, g1, oe_n, oa);
    chk(g0 == e0, "R6", {tag, " dx ch0"}, g0, e0);
    chk(g1 == e1, "R6", {tag, " dx ch1"}, g1, e1);
    chk(oe_n == 8, "R9", {tag, " drive length"}, oe_n, 8);
    chk(oa == 2'b00, "R9", {tag, " float after sample"}, oa, 0);
    chk(rxv_n == 1, "R7", {tag, " strobe count"}, rxv_n, 1);
    chk(rxv_d == {r1, r0}, "R8", {tag, " rx bytes"}, rxv_d, {r1, r0});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1; fails++;
      $display("FAIL all watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] g0, g1; int oe_n; logic [1:0] oa;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sclk_oe == 1'b0, "R1", "sclk_oe after reset", sclk_oe, 0);
    chk(dx_oe == 2'b00, "R1", "dx_oe after reset", dx_oe, 0);
    chk(frame == 1'b0, "R1", "frame after reset", frame, 0);
    chk(rx_valid == 1'b0, "R1", "rx_valid after reset", rx_valid, 0);

    write_hold(8'hA5, 8'h3C);
    ext_bit(1, 1, 2'b11); ext_bit(1, 1, 2'b11);
    do_frame("f1 staged zero", 8'h96, 8'h4B, 8'h00, 8'h00);
    do_frame("f2 staged hold", 8'h21, 8'hDE, 8'hA5, 8'h3C);
    write_hold(8'h0F, 8'hF0);
    do_frame("f3 late write unused", 8'h80, 8'h01, 8'hA5, 8'h3C);
    do_frame("f4 new hold", 8'h5C, 8'hE3, 8'h0F, 8'hF0);
    ext_frame(4, 8'hFF, 8'hFF, g0, g1, oe_n, oa);
    chk(rxv_n == 0, "R7", "short receive frame gives no strobe", rxv_n, 0);
    ext_bit(1, 1, 2'b11); ext_bit(1, 1, 2'b11);

    loop_en = 1'b1;
    @(negedge clk); cfg_wr = 1'b1; cfg_ext = 1'b0;
    @(negedge clk); cfg_wr = 1'b0;
    chk(sclk_oe == 1'b1, "R10", "sclk_oe after switch to master", sclk_oe, 1);
    repeat (CPB * FB + 800) @(negedge clk);
    write_hold(8'h5A, 8'hC3);
    repeat (CPB * FB) @(negedge clk);
    write_hold(8'h81, 8'h7E);
    repeat (CPB * FB) @(negedge clk);
    @(posedge dx_oe[0]);
    repeat (3 * CPB) @(negedge clk);
    chk(dx_oe == 2'b11, "R4", "mid-sample drive before switch", dx_oe, 3);
    cfg_wr = 1'b1; cfg_ext = 1'b1;
    @(negedge clk); cfg_wr = 1'b0;
    chk(dx_oe == 2'b00, "R10", "dx_oe after abandon", dx_oe, 0);
    chk(sclk_oe == 1'b0, "R10", "sclk_oe after switch to slave", sclk_oe, 0);
    chk(frame == 1'b0, "R10", "frame after switch to slave", frame, 0);
    loop_en = 1'b0;
    ext_bit(1, 1, 2'b11); ext_bit(1, 1, 2'b11);
    ext_frame(8, 8'h3A, 8'hC5, g0, g1, oe_n, oa);
    chk({g1, g0} == 16'h0000, "R10", "staged byte cleared by mode change", {g1, g0}, 0);
    chk(rxv_d == 16'hC53A, "R7", "receive after return to slave", rxv_d, 16'hC53A);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule